// File: doc/BRIEF.md
# Slave DMA Burst Request Controller

This block sits between an on-chip buffer RAM and an external system DMA controller. The external controller is the bus master. Software loads a start address, a byte length, a direction, a burst-size code and a bus width, then pulses an enable. The block raises a request line and counts the read or write strobes that arrive while acknowledge is active. It moves each bus beat to or from the next RAM location, and it drops the request at the end of every burst. It raises the request again once acknowledge has been released, as long as bytes remain.

The bus is 16 or 32 bits wide. Burst size is given in bytes, so a narrow bus needs twice as many strobes for the same burst. The request and acknowledge lines each have a programmable active level. An odd byte length is padded on the bus to a whole beat. On writes, byte enables limit the RAM update to the programmed byte count. Completion sets a sticky status flag, and that flag drives an interrupt output when the interrupt is enabled.

Top module: `dma_burst_ctl`

## Requirements
- R1: A pulse on `cfg_start` while idle, with a nonzero length, makes `dreq` active from the next clock edge. It also clears `xfer_done`.
- R2: In 32-bit mode (`cfg_wide`=1), `cfg_bsz` codes 0, 1, 2, 3 give bursts of 1, 4, 8, 16 strobes (4, 16, 32, 64 bytes). In 16-bit mode the same code gives twice as many strobes. Read data appears on `bus_rdata` in the strobe cycle; in 16-bit mode it is on bits [15:0] and the upper bits are zero.
- R3: `dreq` goes inactive combinationally during the last strobe of a burst. It becomes active again one clock after acknowledge is seen inactive, provided bytes remain.
- R4: After the final strobe of a transfer, `dreq` stays inactive until the block is enabled again.
- R5: `cfg_req_pol`=1 makes `dreq` active-high and 0 makes it active-low. `cfg_ack_pol` selects the active level of `dack` in the same way.
- R6: Strobes made while acknowledge is inactive do not write RAM. They also do not move the address or the remaining byte count.
- R7: The start address has its low bit cleared in 16-bit mode and its low two bits cleared in 32-bit mode. `ram_addr` then advances by 2 or 4 on every accepted strobe.
- R8: The number of strobes is the length rounded up to a multiple of 2 (16-bit) or 4 (32-bit), divided by the beat size. Writes enable only the bytes inside the programmed length; padding bytes in RAM stay unchanged.
- R9: `xfer_done` sets on the final strobe, or at once for a zero length, and holds until `irq_clr` or a new start. `irq` equals `xfer_done` AND `irq_en`.
- R10: A `cfg_start` pulse while a transfer is active is ignored. Address, count and settings are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start | input | 1 | Load settings and enable transfer |
| cfg_dir | input | 1 | 1 = bus writes into RAM, 0 = bus reads from RAM |
| cfg_wide | input | 1 | 1 = 32-bit bus, 0 = 16-bit bus |
| cfg_bsz | input | 2 | Burst-size code |
| cfg_addr | input | ADDR_W | Start byte address |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_req_pol | input | 1 | Active level of dreq |
| cfg_ack_pol | input | 1 | Active level of dack |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clear completion flag |
| dreq | output | 1 | Request line to external DMA master |
| dack | input | 1 | Acknowledge from master |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_wdata | input | 32 | Write data from bus |
| bus_rdata | output | 32 | Read data to bus |
| ram_addr | output | ADDR_W | RAM byte address |
| ram_we | output | 1 | RAM write enable |
| ram_be | output | 4 | RAM byte lane enables |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, combinational |
| xfer_done | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt output |

## Verification
The bench targets the final beat of an odd length. A design that ignores the byte count there would overwrite the padding bytes, which the bench pre-fills with a marker value. It also targets the short last burst and the doubled strobe count in 16-bit mode; a miscounted burst shows up as a request dropped one strobe early or late. Stray strobes and a second enable are issued in the gap between bursts. A block that listened to them would shift its address, so later data would land in the wrong RAM locations. Finally, the bench checks that the request reappears exactly one clock after acknowledge is released and stays low after completion, so a request that re-arms at the wrong time is caught.

// File: rtl/dma_burst_ctl.sv
module dma_burst_ctl #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic              cfg_dir,
  input  logic              cfg_wide,
  input  logic [1:0]        cfg_bsz,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_req_pol,
  input  logic              cfg_ack_pol,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic              dreq,
  input  logic              dack,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic [3:0]        ram_be,
  output logic [31:0]       ram_wdata,
  input  logic [31:0]       ram_rdata,
  output logic              xfer_done,
  output logic              irq
);
  localparam int BC_W = 6;

  logic              busy, dir_q, wide_q, req_q, hold_q, done_q;
  logic [1:0]        bsz_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [BC_W-1:0]   bcnt_q;

  function automatic logic [BC_W-1:0] cyc_of(input logic [1:0] code, input logic wide);
    logic [BC_W-1:0] c;
    c = (code == 2'd0) ? BC_W'(1) : (BC_W'(2) << code);
    return wide ? c : (c << 1);
  endfunction

  wire              ack_on    = cfg_ack_pol ? dack : ~dack;
  wire              strobe    = dir_q ? ~wr_n : ~rd_n;
  wire              xfer      = busy & ack_on & strobe;
  wire [LEN_W-1:0]  step_l    = wide_q ? LEN_W'(4) : LEN_W'(2);
  wire [ADDR_W-1:0] step_a    = wide_q ? ADDR_W'(4) : ADDR_W'(2);
  wire              final_x   = rem_q <= step_l;
  wire              burst_end = bcnt_q == BC_W'(1);
  wire              req_live  = req_q & ~(xfer & (burst_end | final_x));

  assign dreq      = cfg_req_pol ? req_live : ~req_live;
  assign xfer_done = done_q;
  assign irq       = done_q & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; dir_q <= 1'b0; wide_q <= 1'b1; req_q <= 1'b0;
      hold_q <= 1'b0; done_q <= 1'b0; bsz_q <= 2'd0;
      addr_q <= '0; rem_q <= '0; bcnt_q <= BC_W'(1);
    end else begin
      if (irq_clr) done_q <= 1'b0;
      if (cfg_start && !busy) begin
        dir_q  <= cfg_dir;
        wide_q <= cfg_wide;
        bsz_q  <= cfg_bsz;
        addr_q <= cfg_wide ? {cfg_addr[ADDR_W-1:2], 2'b00} : {cfg_addr[ADDR_W-1:1], 1'b0};
        rem_q  <= cfg_len;
        bcnt_q <= cyc_of(cfg_bsz, cfg_wide);
        busy   <= cfg_len != '0;
        req_q  <= cfg_len != '0;
        hold_q <= 1'b0;
        done_q <= cfg_len == '0;
      end else if (xfer) begin
        addr_q <= addr_q + step_a;
        rem_q  <= final_x ? '0 : rem_q - step_l;
        if (final_x) begin
          busy <= 1'b0; req_q <= 1'b0; hold_q <= 1'b0; done_q <= 1'b1;
        end else if (burst_end) begin
          req_q <= 1'b0; hold_q <= 1'b1; bcnt_q <= cyc_of(bsz_q, wide_q);
        end else begin
          bcnt_q <= bcnt_q - BC_W'(1);
        end
      end else if (hold_q && !ack_on) begin
        req_q <= 1'b1; hold_q <= 1'b0;
      end
    end
  end

  logic [3:0] be_raw;
  always_comb begin
    if (wide_q)
      be_raw = (rem_q >= LEN_W'(4)) ? 4'b1111 :
               (rem_q == LEN_W'(3)) ? 4'b0111 :
               (rem_q == LEN_W'(2)) ? 4'b0011 : 4'b0001;
    else begin
      be_raw = (rem_q >= LEN_W'(2)) ? 4'b0011 : 4'b0001;
      if (addr_q[1]) be_raw = be_raw << 2;
    end
  end

  assign ram_addr  = addr_q;
  assign ram_we    = xfer & dir_q;
  assign ram_be    = ram_we ? be_raw : 4'b0000;
  assign ram_wdata = wide_q ? bus_wdata : {bus_wdata[15:0], bus_wdata[15:0]};
  assign bus_rdata = wide_q ? ram_rdata :
                     {16'h0000, addr_q[1] ? ram_rdata[31:16] : ram_rdata[15:0]};

  assert_addr_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (wide_q ? (addr_q[1:0] == 2'b00) : (addr_q[0] == 1'b0)));

  assert_quiet_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer) |=> ($stable(addr_q) && $stable(rem_q)));

  assert_restart_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_start) |=> ($stable(dir_q) && $stable(wide_q) && $stable(bsz_q)));

  assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && (burst_end || final_x)) |=> !req_q);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !busy);

  assert_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_be != 4'b0000));
endmodule

// File: tb/dma_burst_ctl_bench.sv
`timescale 1ns/1ps
module dma_burst_ctl_bench;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = 12;

  logic clk = 0, rst_n = 0;
  logic cfg_start = 0, cfg_dir = 0, cfg_wide = 1, cfg_req_pol = 1, cfg_ack_pol = 1;
  logic [1:0] cfg_bsz = 0;
  logic [ADDR_W-1:0] cfg_addr = 0;
  logic [LEN_W-1:0] cfg_len = 0;
  logic irq_en = 0, irq_clr = 0, dack = 0, rd_n = 1, wr_n = 1;
  logic [31:0] bus_wdata = 0;
  logic dreq, ram_we, xfer_done, irq;
  logic [31:0] bus_rdata, ram_wdata, ram_rdata;
  logic [ADDR_W-1:0] ram_addr;
  logic [3:0] ram_be;
  logic [7:0] mem [0:4095];
  int vec = 0, bad = 0;

  always #4 clk = ~clk;

  dma_burst_ctl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dma_burst_ctl (
    .clk, .rst_n, .cfg_start, .cfg_dir, .cfg_wide, .cfg_bsz, .cfg_addr, .cfg_len,
    .cfg_req_pol, .cfg_ack_pol, .irq_en, .irq_clr, .dreq, .dack, .rd_n, .wr_n,
    .bus_wdata, .bus_rdata, .ram_addr, .ram_we, .ram_be, .ram_wdata, .ram_rdata,
    .xfer_done, .irq);

  wire [11:0] wbase = {ram_addr[11:2], 2'b00};
  assign ram_rdata = {mem[wbase+3], mem[wbase+2], mem[wbase+1], mem[wbase]};
  always @(posedge clk)
    if (ram_we)
      for (int i = 0; i < 4; i++)
        if (ram_be[i]) mem[wbase+i] <= ram_wdata[8*i +: 8];

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h5A ^ 8'(a >> 8);
  endfunction

  function automatic logic [31:0] word(input int a, input bit wide);
    if (wide) return {pat(a+3), pat(a+2), pat(a+1), pat(a)};
    return {16'h0000, pat(a+1), pat(a)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(input bit dir, input bit wide, input logic [1:0] code,
                          input int addr, input int len, input bit rp, input bit ap,
                          input int meddle);
    int step, n, bc, base, cnt, k, exp, guard, errs;
    bit last, off;
    step = wide ? 4 : 2;
    n = (len + step - 1) / step;
    bc = (code == 0) ? 1 : (1 << (code + 1));
    if (!wide) bc = bc * 2;
    base = addr & ~(step - 1);
    cnt = 0;
    @(negedge clk);
    cfg_dir = dir; cfg_wide = wide; cfg_bsz = code; cfg_addr = ADDR_W'(addr);
    cfg_len = LEN_W'(len); cfg_req_pol = rp; cfg_ack_pol = ap;
    dack = ~ap; rd_n = 1; wr_n = 1; cfg_start = 1;
    @(negedge clk);
    cfg_start = 0;
    chk(dreq === rp, "R1", "request after enable", dreq, rp);
    chk(xfer_done === 0, "R1", "done cleared by start", xfer_done, 0);
    while (cnt < n) begin
      guard = 0;
      while (dreq !== rp && guard < 50) begin @(negedge clk); guard++; end
      exp = (n - cnt < bc) ? n - cnt : bc;
      k = 0; last = 0;
      dack = ap;
      while (!last && k < 64) begin
        if (dir) begin wr_n = 0; bus_wdata = word(base + cnt*step, wide); end
        else rd_n = 0;
        #1;
        chk(ram_addr == ADDR_W'(base + cnt*step), "R7", "beat address", ram_addr, base + cnt*step);
        if (!dir) chk(bus_rdata == word(base + cnt*step, wide), "R2", "read data",
                      bus_rdata, word(base + cnt*step, wide));
        last = (dreq !== rp);
        @(negedge clk);
        k++; cnt++;
      end
      wr_n = 1; rd_n = 1; dack = ~ap;
      chk(k == exp, "R2", "strobes in burst", k, exp);
      if (cnt < n) begin
        if (meddle == 0) begin
          #1;
          chk(dreq !== rp, "R3", "request low in gap", dreq, ~rp);
          @(negedge clk);
          chk(dreq === rp, "R3", "request back one clock after ack release", dreq, rp);
        end else if (meddle == 1) begin
          for (int j = 0; j < 3; j++) begin
            wr_n = 0; rd_n = 0; #1;
            chk(!ram_we && ram_addr == ADDR_W'(base + cnt*step), "R6",
                "stray strobe without ack", {ram_we, ram_addr}, base + cnt*step);
            @(negedge clk);
          end
          wr_n = 1; rd_n = 1;
        end else begin
          cfg_addr = ADDR_W'(addr ^ 'h80); cfg_len = LEN_W'(4); cfg_wide = ~wide;
          cfg_start = 1;
          @(negedge clk);
          cfg_start = 0; #1;
          chk(ram_addr == ADDR_W'(base + cnt*step), "R10", "restart while busy",
              ram_addr, base + cnt*step);
        end
      end
    end
    chk(cnt == n, "R8", "total strobes", cnt, n);
    #1;
    chk(xfer_done === 1, "R9", "done flag", xfer_done, 1);
    chk(irq === irq_en, "R9", "irq follows enable", irq, irq_en);
    off = 1;
    for (int j = 0; j < 10; j++) begin @(negedge clk); if (dreq === rp) off = 0; end
    chk(off, "R4", "request stays idle after end", !off, 0);
    if (dir) begin
      errs = 0;
      for (int i = 0; i < n*step; i++)
        if (mem[base+i] !== ((i < len) ? pat(base+i) : 8'hEE)) errs++;
      chk(errs == 0, "R8", "RAM bytes vs programmed length", errs, 0);
    end
  endtask

  task automatic t_reset;
    #1;
    chk(dreq === 1'b0, "R5", "reset request level", dreq, 0);
    chk(xfer_done === 0 && irq === 0, "R9", "reset flags", {xfer_done, irq}, 0);
  endtask

  task automatic t_zero_len;
    @(negedge clk);
    cfg_len = 0; cfg_req_pol = 1; irq_en = 1; cfg_start = 1;
    @(negedge clk);
    cfg_start = 0; #1;
    chk(dreq === 0, "R9", "no request for zero length", dreq, 0);
    chk(xfer_done === 1 && irq === 1, "R9", "zero length completes", {xfer_done, irq}, 3);
  endtask

  task automatic t_polarity_idle;
    @(negedge clk);
    cfg_req_pol = 0; #1;
    chk(dreq === 1, "R5", "idle level active-low", dreq, 1);
    cfg_req_pol = 1; #1;
    chk(dreq === 0, "R5", "idle level active-high", dreq, 0);
  endtask

  task automatic t_clear;
    @(negedge clk);
    irq_en = 1; irq_clr = 1;
    @(negedge clk);
    irq_clr = 0; #1;
    chk(xfer_done === 0 && irq === 0, "R9", "clear flag", {xfer_done, irq}, 0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_polarity_idle();
    irq_en = 1;
    run_xfer(1, 1, 2'd1, 'h100, 40, 1, 1, 0);
    run_xfer(1, 0, 2'd1, 'h200, 20, 1, 1, 0);
    irq_en = 0;
    run_xfer(1, 1, 2'd0, 'h300, 7, 1, 1, 0);
    run_xfer(1, 0, 2'd0, 'h380, 5, 1, 1, 0);
    irq_en = 1;
    run_xfer(0, 1, 2'd2, 'h100, 40, 1, 1, 0);
    run_xfer(1, 0, 2'd2, 'h500, 24, 0, 0, 0);
    run_xfer(1, 1, 2'd1, 'h602, 8, 1, 1, 0);
    run_xfer(1, 1, 2'd0, 'h700, 12, 1, 1, 1);
    run_xfer(1, 0, 2'd1, 'h800, 24, 1, 1, 2);
    run_xfer(0, 0, 2'd3, 'h800, 24, 1, 0, 0);
    t_clear();
    t_zero_len();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule